// File: doc/BRIEF.md
# Clustered Test-and-Set Semaphores with Deadlock Detection

This block holds the shared semaphore bits of a small multiprocessor whose CPUs are grouped into clusters. Each CPU presents a cluster number, and that number alone picks the bank of semaphore bits the CPU reaches. A CPU raises a test-and-set request with a bit index. If the bit is clear, the request succeeds in the same cycle and the bit becomes set. If the bit is set, the CPU is told to hold issue and it keeps the request up, which retries the test every cycle. Any CPU can also clear a bit in its own bank.

Per-cluster logic watches for the case where every CPU assigned to a cluster is holding on a test-and-set. When that happens, each such CPU that is not running in monitor mode gets a deadlock flag and a one-cycle exchange request, which lets supervisory software break the stall.

Top module: `cluster_sem`

## Requirements
- R1: The cluster number of a CPU selects its semaphore bank. The same bit index in two different clusters refers to two independent bits, and a clear only affects the clearing CPU's own bank.
- R2: A test-and-set on a clear bit asserts `ts_grant` for that CPU in the same cycle. The bit reads as set from the next cycle on.
- R3: A test-and-set on a set bit asserts `ts_hold` and not `ts_grant`. The test is repeated every cycle in which the request is held.
- R4: When several CPUs test-and-set the same clear bit of the same cluster in one cycle, only the lowest-numbered CPU is granted and the others hold.
- R5: A clear request makes the bit clear from the next cycle. A CPU holding on that bit is granted in the cycle after the clear, and when a clear and a grant hit the same bit in one cycle, the set wins.
- R6: `dl_flag[i]` is high in the cycle after a cycle in which every CPU of CPU i's cluster held on a test-and-set and CPU i was not in monitor mode, and it is low otherwise.
- R7: A CPU in monitor mode never receives `dl_flag` in the following cycle.
- R8: `xchg_req[i]` pulses for exactly one cycle, in the first cycle of each run of `dl_flag[i]` being high.
- R9: A cluster in which any member CPU is not holding reports no deadlock, and a cluster with no member CPU never reports one.
- R10: After reset all semaphore bits are clear and `dl_flag` and `xchg_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cluster | input | NCPU*CLW | Cluster number per CPU, CPU i at bits [i*CLW +: CLW] |
| cpu_monitor | input | NCPU | Monitor-mode state per CPU |
| ts_req | input | NCPU | Test-and-set request per CPU |
| ts_idx | input | NCPU*IXW | Bit index of the test-and-set, CPU i at [i*IXW +: IXW] |
| clr_req | input | NCPU | Clear-semaphore request per CPU |
| clr_idx | input | NCPU*IXW | Bit index of the clear, CPU i at [i*IXW +: IXW] |
| ts_grant | output | NCPU | Test-and-set succeeded this cycle |
| ts_hold | output | NCPU | CPU must hold issue this cycle |
| dl_flag | output | NCPU | Deadlock flag per CPU (registered) |
| xchg_req | output | NCPU | One-cycle exchange request per CPU (registered) |

## Verification
The hardest state to reach is a true cluster-wide stall. Every member of one cluster must hold at once, so first a CPU wins the bit, and then all members, including the earlier winner, re-request the now-set bit while a monitor-mode member sits among them. The bench then keeps the stall up for several cycles so that the one-cycle exchange pulse can be seen apart from the level flag. It also runs a partially stalled cluster and a single-member cluster beside the stalled one, so that the deadlock detection can be seen to stay within a cluster.

// File: rtl/cluster_sem_pkg.sv
package cluster_sem_pkg;
    localparam int DEF_NCPU     = 4;
    localparam int DEF_NCLUSTER = 4;
    localparam int DEF_NBITS    = 32;
endpackage

// File: rtl/tas_arbiter.sv
module tas_arbiter #(
    parameter int NCPU     = 4,
    parameter int NCLUSTER = 4,
    parameter int NBITS    = 32,
    localparam int CLW     = $clog2(NCLUSTER),
    localparam int IXW     = $clog2(NBITS)
) (
    input  logic [NCPU-1:0]           req,
    input  logic [NCPU*IXW-1:0]       idx,
    input  logic [NCPU*CLW-1:0]       cl,
    input  logic [NCLUSTER*NBITS-1:0] sem,
    output logic [NCPU-1:0]           grant
);
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        logic [CLW-1:0] my_cl;
        logic [IXW-1:0] my_ix;
        logic           beaten;
        assign my_cl = cl[i*CLW +: CLW];
        assign my_ix = idx[i*IXW +: IXW];
        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (req[j] && cl[j*CLW +: CLW] == my_cl && idx[j*IXW +: IXW] == my_ix)
                    beaten = 1'b1;
            end
            grant[i] = req[i] && !beaten && !sem[int'(my_cl)*NBITS + int'(my_ix)];
        end
    end
endmodule

// File: rtl/stall_detect.sv
module stall_detect #(
    parameter int NCPU     = 4,
    parameter int NCLUSTER = 4,
    localparam int CLW     = $clog2(NCLUSTER)
) (
    input  logic [NCPU-1:0]     hold,
    input  logic [NCPU*CLW-1:0] cl,
    output logic [NCLUSTER-1:0] dead
);
    for (genvar c = 0; c < NCLUSTER; c++) begin : g_cl
        logic [NCPU-1:0] member;
        always_comb begin
            for (int i = 0; i < NCPU; i++)
                member[i] = (cl[i*CLW +: CLW] == CLW'(c));
            dead[c] = (|member) && ((member & ~hold) == '0);
        end
    end
endmodule

// File: rtl/cluster_sem.sv
module cluster_sem
    import cluster_sem_pkg::*;
#(
    parameter int NCPU     = DEF_NCPU,
    parameter int NCLUSTER = DEF_NCLUSTER,
    parameter int NBITS    = DEF_NBITS,
    localparam int CLW     = $clog2(NCLUSTER),
    localparam int IXW     = $clog2(NBITS),
    localparam int PW      = $clog2(NCLUSTER*NBITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCPU*CLW-1:0] cpu_cluster,
    input  logic [NCPU-1:0]     cpu_monitor,
    input  logic [NCPU-1:0]     ts_req,
    input  logic [NCPU*IXW-1:0] ts_idx,
    input  logic [NCPU-1:0]     clr_req,
    input  logic [NCPU*IXW-1:0] clr_idx,
    output logic [NCPU-1:0]     ts_grant,
    output logic [NCPU-1:0]     ts_hold,
    output logic [NCPU-1:0]     dl_flag,
    output logic [NCPU-1:0]     xchg_req
);
    typedef struct packed {
        logic [NCLUSTER*NBITS-1:0] sem;
        logic [NCPU-1:0]           dl;
        logic [NCPU-1:0]           xc;
    } state_t;

    state_t st_d, st_q;
    logic [NCLUSTER-1:0] dead;

    tas_arbiter #(.NCPU(NCPU), .NCLUSTER(NCLUSTER), .NBITS(NBITS)) u_arb (
        .req(ts_req), .idx(ts_idx), .cl(cpu_cluster), .sem(st_q.sem), .grant(ts_grant)
    );

    assign ts_hold = ts_req & ~ts_grant;

    stall_detect #(.NCPU(NCPU), .NCLUSTER(NCLUSTER)) u_det (
        .hold(ts_hold), .cl(cpu_cluster), .dead(dead)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCPU; i++)
            if (clr_req[i])
                st_d.sem[int'(cpu_cluster[i*CLW +: CLW])*NBITS + int'(clr_idx[i*IXW +: IXW])] = 1'b0;
        for (int i = 0; i < NCPU; i++)
            if (ts_grant[i])
                st_d.sem[int'(cpu_cluster[i*CLW +: CLW])*NBITS + int'(ts_idx[i*IXW +: IXW])] = 1'b1;
        for (int i = 0; i < NCPU; i++)
            st_d.dl[i] = dead[cpu_cluster[i*CLW +: CLW]] && !cpu_monitor[i];
        st_d.xc = st_d.dl & ~st_q.dl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dl_flag  = st_q.dl;
    assign xchg_req = st_q.xc;

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        logic [PW-1:0] pos;
        assign pos = PW'(cpu_cluster[i*CLW +: CLW]) * PW'(NBITS) + PW'(ts_idx[i*IXW +: IXW]);

        assert_set_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ts_grant[i] |=> st_q.sem[$past(pos)]);
        assert_flag_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dl_flag[i] |-> $past(ts_hold[i]));
        assert_monitor_spared_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_monitor[i] |=> !dl_flag[i]);
        assert_xchg_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            xchg_req[i] |-> (dl_flag[i] && !$past(dl_flag[i])));

        for (genvar j = i + 1; j < NCPU; j++) begin : g_pair
            assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(ts_grant[i] && ts_grant[j] && g_chk[i].pos == g_chk[j].pos));
        end
    end
endmodule

// File: tb/tb_cluster_sem.sv
module tb_cluster_sem;
    localparam int PERIOD = 10;
    localparam int N = 4, NC = 4, NB = 32;
    localparam int CLW = $clog2(NC), IXW = $clog2(NB);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N*CLW-1:0] cl = '0;
    logic [N-1:0] mon = '0, req = '0, clr = '0;
    logic [N*IXW-1:0] idx = '0, cidx = '0;
    logic [N-1:0] grant, hold, dl, xc;

    cluster_sem dut (
        .clk(clk), .rst_n(rst_n), .cpu_cluster(cl), .cpu_monitor(mon),
        .ts_req(req), .ts_idx(idx), .clr_req(clr), .clr_idx(cidx),
        .ts_grant(grant), .ts_hold(hold), .dl_flag(dl), .xchg_req(xc)
    );

    always #(PERIOD/2) clk = ~clk;

    bit msem [NC][NB];
    bit mdl [N];
    bit mxc [N];
    int vectors = 0, fails = 0;
    bit finished = 0;
    string tag = "R10";

    function automatic int clof(int i); return int'(cl[i*CLW +: CLW]); endfunction
    function automatic int ixof(int i); return int'(idx[i*IXW +: IXW]); endfunction

    function automatic bit exp_grant(int i);
        if (!req[i] || msem[clof(i)][ixof(i)]) return 0;
        for (int j = 0; j < i; j++)
            if (req[j] && clof(j) == clof(i) && ixof(j) == ixof(i)) return 0;
        return 1;
    endfunction

    task automatic put(int i, int c); cl[i*CLW +: CLW] = CLW'(c); endtask
    task automatic ts(int i, int b); req[i] = 1'b1; idx[i*IXW +: IXW] = IXW'(b); endtask
    task automatic cl_bit(int i, int b); clr[i] = 1'b1; cidx[i*IXW +: IXW] = IXW'(b); endtask

    task automatic cyc();
        bit g [N];
        bit nd [N];
        #1;
        vectors++;
        for (int i = 0; i < N; i++) begin
            g[i] = exp_grant(i);
            if (grant[i] !== g[i]) begin fails++; $display("FAIL %s cpu%0d grant actual=%b expected=%b", tag, i, grant[i], g[i]); end
            if (hold[i] !== (req[i] && !g[i])) begin fails++; $display("FAIL %s cpu%0d hold actual=%b expected=%b", tag, i, hold[i], req[i] && !g[i]); end
            if (dl[i] !== mdl[i]) begin fails++; $display("FAIL %s cpu%0d dl_flag actual=%b expected=%b", tag, i, dl[i], mdl[i]); end
            if (xc[i] !== mxc[i]) begin fails++; $display("FAIL %s cpu%0d xchg_req actual=%b expected=%b", tag, i, xc[i], mxc[i]); end
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            int members = 0, held = 0;
            for (int j = 0; j < N; j++)
                if (clof(j) == clof(i)) begin
                    members++;
                    if (req[j] && !g[j]) held++;
                end
            nd[i] = (members > 0) && (held == members) && !mon[i];
        end
        for (int i = 0; i < N; i++)
            if (clr[i]) msem[clof(i)][int'(cidx[i*IXW +: IXW])] = 0;
        for (int i = 0; i < N; i++)
            if (g[i]) msem[clof(i)][ixof(i)] = 1;
        for (int i = 0; i < N; i++) begin
            mxc[i] = nd[i] && !mdl[i];
            mdl[i] = nd[i];
        end
        @(negedge clk);
    endtask

    task automatic idle(); req = '0; clr = '0; endtask

    initial begin
        #(PERIOD*20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        put(0, 0); put(1, 1); put(2, 0); put(3, 2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state, idle; cluster 3 empty (R9)
        tag = "R10"; cyc(); cyc();
        // R2: first test-and-set wins
        tag = "R2"; ts(0, 5); cyc(); idle();
        // R3: bit now set, cpu2 holds; cpu0 idle so no deadlock (R9)
        tag = "R3"; ts(2, 5); cyc(); cyc(); tag = "R9"; cyc();
        // R1: same index in cluster 1 is independent
        tag = "R1"; ts(1, 5); cyc(); req[1] = 1'b0;
        tag = "R1"; cl_bit(1, 5); cyc(); clr = '0; cyc();
        // R5: cpu0 clears bit 5 of cluster 0 while cpu2 holds
        tag = "R5"; cl_bit(0, 5); cyc(); clr = '0; cyc(); idle(); cyc();
        // R5: clear and set collide on one bit
        tag = "R5"; ts(0, 9); cl_bit(2, 9); cyc(); idle(); ts(2, 9); cyc(); idle();
        // R4: three CPUs race for one clear bit in cluster 2
        put(0, 2); put(2, 2); put(3, 2);
        tag = "R4"; ts(0, 31); ts(2, 31); ts(3, 31); cyc();
        req[0] = 1'b0; tag = "R9"; cyc(); cyc();
        // R6/R7/R8: whole cluster 2 stalls, cpu3 in monitor mode
        mon[3] = 1'b1; ts(0, 31);
        tag = "R6"; cyc(); tag = "R8"; cyc(); cyc(); tag = "R7"; cyc();
        // R1: a clear in cluster 1 does not free cluster 2
        tag = "R1"; cl_bit(1, 31); cyc(); clr = '0;
        // release via cluster 2 clear; stall ends
        tag = "R5"; req[0] = 1'b0; cl_bit(0, 31); cyc(); clr = '0; cyc(); idle(); cyc(); cyc();
        // R6/R8: single-member cluster 1 stalls, then re-stalls
        tag = "R6"; ts(1, 3); cyc(); cyc(); cyc(); cyc();
        req[1] = 1'b0; tag = "R8"; cyc(); ts(1, 3); cyc(); cyc(); idle(); cyc();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule